// File: doc/BRIEF.md
# Timer/Event Counter with Halt Wakeup

This block is an 8-bit up-counter driven either by a divided internal clock (timer mode) or by rising edges of an external event line (event mode). Software sets a start value through a preload register, picks the mode and a power-of-two division ratio in a control register, and starts or stops counting with a single run bit. When the count passes 0xFF it is reloaded from the preload register in the same cycle, and an interrupt request flag is raised. The interrupt output is the request flag gated by a master enable and a timer enable.

A halt input stands for the low-power Idle/Sleep state. While halted, timer mode stops counting, because the internal clock is treated as stopped, but event mode keeps counting external edges. An overflow during the halt raises a wakeup output. The wakeup is suppressed for the whole halt if the request flag was already set on the cycle the halt began. Software can use this to prevent the wakeup on purpose.

Top module: `evtimer_top`

## Requirements
- R1: After reset the count, preload, control and interrupt registers all read 0, and `irq` and `wake` are low.
- R2: Address 0 writes the preload register. While the counter is stopped, the same write also loads the count. A read of address 0 returns the current count.
- R3: Control register (address 1) bit 4 is the run bit. While it is 0 the count holds its value, apart from preload writes.
- R4: Control bits 2:0 select a ratio of 2^sel. In timer mode (control bit 3 = 0) the count advances by one every 2^sel clock cycles.
- R5: A count step from 0xFF loads the preload value in the same cycle and sets the request flag.
- R6: Address 2 holds the master enable (bit 0), the timer enable (bit 1) and the request flag (bit 2). `irq` is high exactly when all three are 1.
- R7: Writing address 2 with bit 2 = 0 clears the request flag. If an overflow occurs in the same cycle, the flag ends up set.
- R8: In event mode (control bit 3 = 1), each rising edge of `evt_in` is one count source pulse. The pulse passes a two-flop synchronizer, and the count changes on the third rising clock edge after the input rises.
- R9: While `halt` is high, timer mode does not count and event mode keeps counting.
- R10: Suppose the request flag was 0 on the first halt cycle. An overflow during the halt then raises `wake` one cycle later. `wake` stays high until `halt` falls and drops on the next cycle.
- R11: If the request flag was 1 on the first halt cycle, no overflow during that halt raises `wake`.
- R12: The prescaler is cleared whenever the run bit is 0. After a restart, the first count step takes a full 2^sel source pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address (0 count/preload, 1 control, 2 interrupt) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| evt_in | input | 1 | Asynchronous external event line |
| halt | input | 1 | Low-power halt state |
| irq | output | 1 | Gated interrupt request |
| wake | output | 1 | Wakeup request raised by an overflow during halt |

## Verification
A software clear of the request flag can land in the same cycle as a counter overflow. The result must be a set flag. To provoke this, the bench loads 0xFE with a ratio of 1, so an overflow occurs every second cycle, and holds a clearing write on the interrupt register for several cycles. Every cycle is compared against a behavioural reference model, and the bench also confirms that the flag is seen set during the clearing writes. A second overlap is the first halt cycle coinciding with a flag that is already set. This is judged by halting after an earlier overflow has left the flag high and confirming that `wake` stays low through a later overflow.

// File: rtl/evtimer_pkg.sv
package evtimer_pkg;

    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        ADDR_COUNT = 2'd0,
        ADDR_CTRL  = 2'd1,
        ADDR_INT   = 2'd2,
        ADDR_SPARE = 2'd3
    } evt_addr_e;

    // control register fields
    localparam int RUN_BIT  = 4;
    localparam int MODE_BIT = 3;

    // interrupt register fields
    localparam int MIE_BIT  = 0;
    localparam int TIE_BIT  = 1;
    localparam int FLAG_BIT = 2;

endpackage

// File: rtl/evtimer_sync.sv
module evtimer_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    // stages 0..STAGES-1 synchronize, stage STAGES keeps the previous value
    localparam int LEN = STAGES + 1;

    logic [LEN-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[LEN-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];

endmodule

// File: rtl/evtimer_prescale.sv
module evtimer_prescale #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             pulse,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int PRE_W = (1 << SEL_W) - 1;

    logic [PRE_W-1:0] pre_d, pre_q;
    logic [PRE_W:0]   one_hot;
    logic [PRE_W-1:0] mask;

    always_comb begin
        one_hot = (PRE_W + 1)'(1) << sel;
        mask    = one_hot[PRE_W-1:0] - PRE_W'(1);
        tick    = pulse && ((pre_q & mask) == mask);
        pre_d   = pre_q;
        if (clr)        pre_d = '0;
        else if (tick)  pre_d = '0;
        else if (pulse) pre_d = pre_q + PRE_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end

endmodule

// File: rtl/evtimer_wake.sv
module evtimer_wake (
    input  logic clk,
    input  logic rst_n,
    input  logic halt,
    input  logic flag,
    input  logic ovf,
    output logic wake
);
    typedef struct packed {
        logic halt_prev;
        logic blocked;
        logic wake;
    } wk_t;

    wk_t wk_d, wk_q;
    logic halt_start;
    logic block_now;

    always_comb begin
        halt_start = halt & ~wk_q.halt_prev;
        block_now  = halt_start ? flag : wk_q.blocked;
        wk_d           = wk_q;
        wk_d.halt_prev = halt;
        if (halt_start) wk_d.blocked = flag;
        if (halt) wk_d.wake = wk_q.wake | (ovf & ~block_now);
        else      wk_d.wake = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wk_q <= '0;
        else        wk_q <= wk_d;
    end

    assign wake = wk_q.wake;

endmodule

// File: rtl/evtimer_top.sv
module evtimer_top
    import evtimer_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int SEL_W       = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [1:0]        bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    input  logic              evt_in,
    input  logic              halt,
    output logic              irq,
    output logic              wake
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] preload;
        logic             run;
        logic             evt;
        logic [SEL_W-1:0] sel;
        logic             mie;
        logic             tie;
        logic             flag;
    } st_t;

    st_t st_d, st_q;

    evt_addr_e addr;
    logic      wr_cnt, wr_ctrl, wr_int;
    logic      rise, pulse, tick, ovf;

    assign addr = evt_addr_e'(bus_addr);

    evtimer_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (evt_in),
        .rise  (rise)
    );

    // timer mode source stops while halted; event mode source keeps running
    assign pulse = st_q.run && (st_q.evt ? rise : !halt);

    evtimer_prescale #(.SEL_W(SEL_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!st_q.run),
        .pulse (pulse),
        .sel   (st_q.sel),
        .tick  (tick)
    );

    assign ovf = tick && (st_q.cnt == CNT_MAX);

    always_comb begin
        wr_cnt  = bus_we && (addr == ADDR_COUNT);
        wr_ctrl = bus_we && (addr == ADDR_CTRL);
        wr_int  = bus_we && (addr == ADDR_INT);
        st_d    = st_q;

        if (tick)                    st_d.cnt = ovf ? st_q.preload : st_q.cnt + CNT_W'(1);
        else if (!st_q.run && wr_cnt) st_d.cnt = bus_wdata;

        if (wr_cnt) st_d.preload = bus_wdata;

        if (wr_ctrl) begin
            st_d.run = bus_wdata[RUN_BIT];
            st_d.evt = bus_wdata[MODE_BIT];
            st_d.sel = bus_wdata[SEL_W-1:0];
        end

        if (wr_int) begin
            st_d.mie  = bus_wdata[MIE_BIT];
            st_d.tie  = bus_wdata[TIE_BIT];
            st_d.flag = bus_wdata[FLAG_BIT];
        end
        if (ovf) st_d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        bus_rdata = '0;
        case (addr)
            ADDR_COUNT: bus_rdata = st_q.cnt;
            ADDR_CTRL: begin
                bus_rdata[RUN_BIT]   = st_q.run;
                bus_rdata[MODE_BIT]  = st_q.evt;
                bus_rdata[SEL_W-1:0] = st_q.sel;
            end
            ADDR_INT: begin
                bus_rdata[MIE_BIT]  = st_q.mie;
                bus_rdata[TIE_BIT]  = st_q.tie;
                bus_rdata[FLAG_BIT] = st_q.flag;
            end
            default: bus_rdata = '0;
        endcase
    end

    assign irq = st_q.flag & st_q.mie & st_q.tie;

    evtimer_wake u_wake (
        .clk   (clk),
        .rst_n (rst_n),
        .halt  (halt),
        .flag  (st_q.flag),
        .ovf   (ovf),
        .wake  (wake)
    );

endmodule

// File: rtl/evtimer_chk.sv
module evtimer_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_we,
    input logic [1:0]       bus_addr,
    input logic [CNT_W-1:0] bus_wdata,
    input logic             halt,
    input logic             wake,
    input logic             tick,
    input logic             ovf,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] preload,
    input logic             run,
    input logic             flag
);
    a_r5_reload: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> cnt == $past(preload));

    a_r5_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> flag);

    a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !ovf) |=> cnt == $past(cnt) + CNT_W'(1));

    a_r3_stopped_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !(bus_we && bus_addr == 2'd0)) |=> $stable(cnt));

    a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == 2'd2 && !bus_wdata[2] && !ovf) |=> !flag);

    a_r7_ovf_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == 2'd2 && ovf) |=> flag);

    a_r10_wake_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake) |-> ($past(ovf) && $past(halt)));

    a_r10_wake_release: assert property (@(posedge clk) disable iff (!rst_n)
        (wake && !halt) |=> !wake);

endmodule

bind evtimer_top evtimer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .halt      (halt),
    .wake      (wake),
    .tick      (tick),
    .ovf       (ovf),
    .cnt       (st_q.cnt),
    .preload   (st_q.preload),
    .run       (st_q.run),
    .flag      (st_q.flag)
);

// File: tb/test_evtimer_top.sv
`timescale 1ns/1ps
module test_evtimer_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_we = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       evt_in = 1'b0;
    logic       halt = 1'b0;
    logic       irq, wake;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    string cur_req = "R1";

    always #4 clk = ~clk;

    evtimer_top i_evtimer_top (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_in(evt_in),
        .halt(halt), .irq(irq), .wake(wake)
    );

    // behavioural reference model
    int m_cnt, m_pl, m_run, m_evt, m_sel, m_mie, m_tie, m_flag;
    int m_pre, m_wake, m_blk, m_hprev;
    bit sync_q[$];

    task automatic model_reset();
        m_cnt = 0; m_pl = 0; m_run = 0; m_evt = 0; m_sel = 0;
        m_mie = 0; m_tie = 0; m_flag = 0; m_pre = 0; m_wake = 0;
        m_blk = 0; m_hprev = 0;
        sync_q = '{1'b0, 1'b0, 1'b0};
    endtask

    initial model_reset();

    always @(posedge clk) begin
        if (!rst_n) model_reset();
        else begin
            bit rise, hstart, blocked, pulse, tick, ovf;
            int mask, old_flag;
            rise    = sync_q[1] && !sync_q[2];
            hstart  = halt && (m_hprev == 0);
            blocked = hstart ? (m_flag != 0) : (m_blk != 0);
            pulse   = (m_run != 0) && ((m_evt != 0) ? rise : !halt);
            mask    = (1 << m_sel) - 1;
            tick    = pulse && ((m_pre & mask) == mask);
            ovf     = tick && (m_cnt == 255);
            old_flag = m_flag;
            if (m_run == 0) m_pre = 0;
            else if (tick) m_pre = 0;
            else if (pulse) m_pre = m_pre + 1;
            if (ovf) m_cnt = m_pl;
            else if (tick) m_cnt = m_cnt + 1;
            else if (m_run == 0 && bus_we && bus_addr == 2'd0) m_cnt = bus_wdata;
            if (bus_we && bus_addr == 2'd0) m_pl = bus_wdata;
            if (bus_we && bus_addr == 2'd1) begin
                m_run = bus_wdata[4]; m_evt = bus_wdata[3]; m_sel = bus_wdata[2:0];
            end
            if (bus_we && bus_addr == 2'd2) begin
                m_mie = bus_wdata[0]; m_tie = bus_wdata[1]; m_flag = bus_wdata[2];
            end
            if (ovf) m_flag = 1;
            if (halt) m_wake = (m_wake != 0 || (ovf && !blocked)) ? 1 : 0;
            else m_wake = 0;
            if (hstart) m_blk = old_flag;
            m_hprev = halt;
            sync_q.push_front(evt_in);
            void'(sync_q.pop_back());
        end
    end

    task automatic check(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(posedge clk) begin
        #2;
        if (rst_n) begin
            int exp_rd;
            case (bus_addr)
                2'd0: exp_rd = m_cnt;
                2'd1: exp_rd = (m_run << 4) | (m_evt << 3) | m_sel;
                2'd2: exp_rd = (m_flag << 2) | (m_tie << 1) | m_mie;
                default: exp_rd = 0;
            endcase
            check(cur_req, "rdata", bus_rdata, exp_rd);
            check(cur_req, "irq", irq, (m_flag & m_mie & m_tie));
            check(cur_req, "wake", wake, m_wake);
        end
    end

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected<150000", cyc);
            summary();
        end
    end

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_addr = 2'd0;
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        @(negedge clk);
        bus_addr = a;
        #1 v = bus_rdata;
        bus_addr = 2'd0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic evt_pulse();
        @(negedge clk); evt_in = 1'b1;
        idle(2); evt_in = 1'b0;
        idle(2);
    endtask

    initial begin
        int v, v2, seen;
        idle(3);
        rst_n = 1'b1;
        // R1 reset state
        rd(2'd0, v); check("R1", "count", v, 0);
        rd(2'd1, v); check("R1", "ctrl", v, 0);
        rd(2'd2, v); check("R1", "int", v, 0);
        check("R1", "irq", irq, 0);
        check("R1", "wake", wake, 0);

        cur_req = "R2";
        wr(2'd0, 8'hF0);
        rd(2'd0, v); check("R2", "count after preload", v, 8'hF0);

        cur_req = "R5";
        wr(2'd2, 8'h03);
        wr(2'd1, 8'h11);
        idle(40);
        rd(2'd2, v); check("R5", "flag after overflow", (v >> 2) & 1, 1);
        check("R6", "irq all enabled", irq, 1);
        wr(2'd1, 8'h01);

        cur_req = "R6";
        wr(2'd2, 8'h05);
        check("R6", "irq timer enable off", irq, 0);
        cur_req = "R7";
        wr(2'd2, 8'h03);
        rd(2'd2, v); check("R7", "flag cleared", (v >> 2) & 1, 0);

        cur_req = "R3";
        rd(2'd0, v); idle(10); rd(2'd0, v2);
        check("R3", "stopped count holds", v2, v);

        cur_req = "R12";
        wr(2'd1, 8'h13); idle(5);
        wr(2'd1, 8'h03);
        wr(2'd1, 8'h13);
        rd(2'd0, v); idle(5); rd(2'd0, v2);
        check("R12", "no early step after restart", v2, v);
        idle(4); rd(2'd0, v2);
        check("R12", "one step after full period", v2, (v + 1) & 8'hFF);
        wr(2'd1, 8'h03);

        cur_req = "R7";
        wr(2'd0, 8'hFE);
        wr(2'd1, 8'h10);
        seen = 0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            bus_we = 1'b1; bus_addr = 2'd2; bus_wdata = 8'h03;
            #1 if (bus_rdata[2]) seen = 1;
        end
        @(negedge clk); bus_we = 1'b0; bus_addr = 2'd0;
        check("R7", "overflow wins over clear", seen, 1);
        wr(2'd1, 8'h00);
        wr(2'd2, 8'h03);

        cur_req = "R4";
        wr(2'd0, 8'h00);
        wr(2'd1, 8'h17);
        idle(300);
        rd(2'd0, v); check("R4", "ratio 128 count", v, 2);
        wr(2'd1, 8'h07);

        cur_req = "R9";
        wr(2'd1, 8'h10);
        @(negedge clk); halt = 1'b1;
        rd(2'd0, v); idle(10); rd(2'd0, v2);
        check("R9", "timer halted holds", v2, v);
        @(negedge clk); halt = 1'b0;
        wr(2'd1, 8'h00);

        cur_req = "R8";
        wr(2'd0, 8'hFD);
        wr(2'd2, 8'h03);
        wr(2'd1, 8'h18);
        evt_pulse();
        rd(2'd0, v); check("R8", "one count per edge", v, 8'hFE);

        cur_req = "R10";
        @(negedge clk); halt = 1'b1;
        evt_pulse(); evt_pulse();
        idle(3);
        check("R10", "wake after halted overflow", wake, 1);
        rd(2'd0, v); check("R9", "event counts in halt", v, 8'hFD);
        @(negedge clk); halt = 1'b0;
        idle(2);
        check("R10", "wake drops after halt", wake, 0);

        cur_req = "R11";
        @(negedge clk); halt = 1'b1;
        evt_pulse(); evt_pulse(); evt_pulse();
        idle(3);
        rd(2'd0, v); check("R11", "overflow occurred", v, 8'hFD);
        check("R11", "no wake with flag preset", wake, 0);
        @(negedge clk); halt = 1'b0;
        idle(4);
        summary();
    end
endmodule